// File: doc/BRIEF.md
# Interrupt-Acknowledge Packet Input Gate

This block sits on a packet stream between a data source and the write side of a scatter-gather DMA engine. When gating is on, it passes one complete packet and then closes. It stays closed until software acknowledges the end-of-transfer interrupt raised for that packet. Each packet therefore has its own interrupt, and interrupts from back-to-back packets cannot merge when data arrives faster than the processor can service them.

The block also holds a two-bit interrupt pending register, one bit for start-of-transfer and one for end-of-transfer. Event pulses set the bits, and a write-one-to-clear acknowledge clears them. The gate reopens on the per-source clear strobe that this acknowledge produces. It does not watch the level of the combined interrupt line. A run-time enable input turns gating on or off, so the same hardware also works without acknowledge-based flow control.

Top module: `pkt_ack_gate`

## Requirements
- R1: After reset the gate is open and both pending bits read zero, so `irq` is low.
- R2: While the gate is open, `m_valid` equals `s_valid` and `s_ready` equals `m_ready`. `m_data` and `m_last` always equal `s_data` and `s_last`.
- R3: With `gate_en` high, the gate closes in the cycle after a beat with `s_last` high is accepted. While the gate is closed and `gate_en` stays high, `s_ready` and `m_valid` are both low.
- R4: A write with `ack_wr` high and `ack_mask[1]` (end-of-transfer) set reopens a closed gate in the next cycle. A write that sets only `ack_mask[0]` leaves the gate closed.
- R5: Dropping `gate_en` while the gate is closed opens it in the same cycle.
- R6: With `gate_en` low, the gate never closes, and packets pass back to back.
- R7: A one-cycle pulse on `sot_evt` sets `irq_pending[0]`, and a pulse on `eot_evt` sets `irq_pending[1]`, from the next cycle on. `irq` is the OR of the pending bits.
- R8: An acknowledge write clears exactly the pending bits whose `ack_mask` bits are one. Bits written with zero keep their value.
- R9: If an event and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: Raising `gate_en` in the middle of a packet does not stall that packet. The gate closes after that packet's last beat.
- R11: Every beat accepted from the source is delivered exactly once and in order. With gating on and one acknowledge per packet, every packet completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Run-time enable for acknowledge gating |
| s_valid | input | 1 | Source beat valid |
| s_ready | output | 1 | Ready towards source |
| s_data | input | DATA_W | Source beat data |
| s_last | input | 1 | Source beat ends a packet |
| m_valid | output | 1 | Beat valid towards DMA |
| m_ready | input | 1 | DMA ready |
| m_data | output | DATA_W | Beat data towards DMA |
| m_last | output | 1 | Last flag towards DMA |
| sot_evt | input | 1 | Start-of-transfer event pulse |
| eot_evt | input | 1 | End-of-transfer event pulse |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_mask | input | 2 | Write-one-to-clear mask (bit 0 start, bit 1 end) |
| irq_pending | output | 2 | Pending bits (bit 0 start, bit 1 end) |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check the handshake pass-through, that the gate shuts after an accepted last beat, the set and clear behaviour of the pending bits with set taking priority, and the reset value. Only the directed scenarios can show the full flows: a start-of-transfer acknowledge does not reopen the gate, the gate opens at once when gating is turned off, enabling mid-packet takes effect late, and a multi-packet run with one acknowledge per packet delivers every beat in order.

// File: rtl/pkt_ack_gate_pkg.sv
package pkt_ack_gate_pkg;

    localparam int unsigned NUM_SRC = 2;

    typedef enum int unsigned {
        SRC_SOT = 0,
        SRC_EOT = 1
    } irq_src_e;

    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_HELD = 1'b1
    } gate_state_e;

    function automatic gate_state_e next_gate(
        input gate_state_e cur,
        input logic        enable,
        input logic        last_taken,
        input logic        release_stb
    );
        if (!enable)          return GATE_OPEN;
        else if (last_taken)  return GATE_HELD;
        else if (release_stb) return GATE_OPEN;
        else                  return cur;
    endfunction

endpackage

// File: rtl/pig_irq_status.sv
module pig_irq_status #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         ack_wr,
    input  logic [N-1:0] ack_mask,
    output logic [N-1:0] pending,
    output logic [N-1:0] clr_stb
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic pend_q;

        assign clr_stb[i] = ack_wr & ack_mask[i];

        always_ff @(posedge clk) begin
            if (rst)             pend_q <= 1'b0;
            else if (evt[i])     pend_q <= 1'b1;
            else if (clr_stb[i]) pend_q <= 1'b0;
        end

        assign pending[i] = pend_q;
    end
endmodule

// File: rtl/pig_flow_gate.sv
module pig_flow_gate
    import pkt_ack_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic gate_en,
    input  logic last_taken,
    input  logic release_stb,
    output logic hold
);
    gate_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_OPEN;
        else     state_q <= next_gate(state_q, gate_en, last_taken, release_stb);
    end

    assign hold = gate_en && (state_q == GATE_HELD);
endmodule

// File: rtl/pkt_ack_gate.sv
module pkt_ack_gate
    import pkt_ack_gate_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gate_en,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [DATA_W-1:0]   s_data,
    input  logic                s_last,
    output logic                m_valid,
    input  logic                m_ready,
    output logic [DATA_W-1:0]   m_data,
    output logic                m_last,
    input  logic                sot_evt,
    input  logic                eot_evt,
    input  logic                ack_wr,
    input  logic [NUM_SRC-1:0]  ack_mask,
    output logic [NUM_SRC-1:0]  irq_pending,
    output logic                irq
);
    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] clr_stb;
    logic               hold;
    logic               last_taken;

    assign evt_vec[SRC_SOT] = sot_evt;
    assign evt_vec[SRC_EOT] = eot_evt;

    pig_irq_status #(.N(NUM_SRC)) u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_vec),
        .ack_wr   (ack_wr),
        .ack_mask (ack_mask),
        .pending  (irq_pending),
        .clr_stb  (clr_stb)
    );

    pig_flow_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .gate_en     (gate_en),
        .last_taken  (last_taken),
        .release_stb (clr_stb[SRC_EOT]),
        .hold        (hold)
    );

    assign s_ready    = m_ready & ~hold;
    assign m_valid    = s_valid & ~hold;
    assign m_data     = s_data;
    assign m_last     = s_last;
    assign last_taken = s_valid & s_ready & s_last;
    assign irq        = |irq_pending;
endmodule

// File: rtl/pkt_ack_gate_chk.sv
module pkt_ack_gate_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              gate_en,
    input logic              s_valid,
    input logic              s_ready,
    input logic [DATA_W-1:0] s_data,
    input logic              s_last,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_last,
    input logic              sot_evt,
    input logic              eot_evt,
    input logic              ack_wr,
    input logic [1:0]        ack_mask,
    input logic [1:0]        irq_pending,
    input logic              irq
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (irq_pending == 2'b00));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> s_valid);

    // R2
    ready_follow_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> m_ready);

    // R11
    beat_intact_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready) |-> (s_valid && s_ready && m_data == s_data && m_last == s_last));

    // R3
    close_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_en && s_valid && s_ready && s_last) |=> (!gate_en || (!s_ready && !m_valid)));

    // R7
    sot_set_chk: assert property (@(posedge clk) disable iff (rst)
        sot_evt |=> irq_pending[0]);

    // R9
    eot_set_chk: assert property (@(posedge clk) disable iff (rst)
        eot_evt |=> irq_pending[1]);

    // R8
    sot_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && ack_mask[0] && !sot_evt) |=> !irq_pending[0]);

    // R8
    eot_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!(ack_wr && ack_mask[1]) && !eot_evt) |=> (irq_pending[1] == $past(irq_pending[1])));

    // R7
    irq_or_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (irq_pending != 2'b00));
endmodule

bind pkt_ack_gate pkt_ack_gate_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_pkt_ack_gate.sv
module tb_pkt_ack_gate;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          gate_en;
    logic          s_valid, s_ready, s_last;
    logic [DW-1:0] s_data;
    logic          m_valid, m_ready, m_last;
    logic [DW-1:0] m_data;
    logic          sot_evt, eot_evt, ack_wr;
    logic [1:0]    ack_mask, irq_pending;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pkt_ack_gate #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .gate_en(gate_en),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .sot_evt(sot_evt), .eot_evt(eot_evt), .ack_wr(ack_wr), .ack_mask(ack_mask),
        .irq_pending(irq_pending), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge and clear one-cycle strobes.
    task automatic cyc();
        @(negedge clk);
        sot_evt = 1'b0; eot_evt = 1'b0; ack_wr = 1'b0; ack_mask = 2'b00;
    endtask

    task automatic idle_src();
        s_valid = 1'b0; s_last = 1'b0; s_data = '0; m_ready = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1; gate_en = 1'b0; idle_src();
        sot_evt = 1'b0; eot_evt = 1'b0; ack_wr = 1'b0; ack_mask = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        // R1
        cyc(); s_valid = 1'b1; m_ready = 1'b1; #1;
        chk(irq_pending, 2'b00, "R1 pending");
        chk(irq, 0, "R1 irq");
        chk({m_valid, s_ready}, 2'b11, "R1 gate open");
        idle_src();
    endtask

    task automatic t_pass();
        // R2
        cyc(); s_valid = 1'b1; s_data = 32'hA5A5_0001; s_last = 1'b1; m_ready = 1'b0; #1;
        chk({m_valid, s_ready}, 2'b10, "R2 valid through");
        chk(m_data, 32'hA5A5_0001, "R2 data");
        chk(m_last, 1, "R2 last");
        cyc(); s_valid = 1'b0; m_ready = 1'b1; #1;
        chk({m_valid, s_ready}, 2'b01, "R2 ready through");
        idle_src();
    endtask

    task automatic t_no_gate();
        // R6
        gate_en = 1'b0;
        for (int b = 0; b < 4; b++) begin
            cyc(); s_valid = 1'b1; s_last = b[0]; s_data = b; #1;
            chk({m_valid, s_ready}, 2'b11, "R6 no gating");
        end
        idle_src();
    endtask

    task automatic t_close_reopen();
        gate_en = 1'b1;
        cyc(); s_valid = 1'b1; s_last = 1'b1; s_data = 32'h11; sot_evt = 1'b1; #1;
        chk(s_ready, 1, "R3 last accepted");
        cyc(); s_data = 32'h22; s_last = 1'b0; eot_evt = 1'b1; #1;
        chk({m_valid, s_ready}, 2'b00, "R3 closed");
        // R7
        chk(irq_pending, 2'b01, "R7 sot set");
        chk(irq, 1, "R7 irq");
        cyc(); #1;
        chk(irq_pending, 2'b11, "R7 eot set");
        chk({m_valid, s_ready}, 2'b00, "R3 stays closed");
        cyc(); ack_wr = 1'b1; ack_mask = 2'b01; #1;
        cyc(); #1;
        chk(irq_pending, 2'b10, "R8 clear sot only");
        chk({m_valid, s_ready}, 2'b00, "R4 sot ack keeps closed");
        cyc(); ack_wr = 1'b1; ack_mask = 2'b10; #1;
        chk({m_valid, s_ready}, 2'b00, "R4 closed during ack");
        cyc(); #1;
        chk({m_valid, s_ready}, 2'b11, "R4 reopened");
        chk(m_data, 32'h22, "R11 held beat");
        chk(irq_pending, 2'b00, "R8 clear eot");
        idle_src();
    endtask

    task automatic t_set_wins();
        // R9
        cyc(); eot_evt = 1'b1; ack_wr = 1'b1; ack_mask = 2'b10; #1;
        cyc(); #1;
        chk(irq_pending, 2'b10, "R9 set wins");
        cyc(); ack_wr = 1'b1; ack_mask = 2'b11; #1;
        cyc(); #1;
        chk(irq_pending, 2'b00, "R8 clear both");
    endtask

    task automatic t_disable_open();
        gate_en = 1'b1;
        cyc(); s_valid = 1'b1; s_last = 1'b1; #1;
        cyc(); s_last = 1'b0; #1;
        chk({m_valid, s_ready}, 2'b00, "R5 closed first");
        cyc(); gate_en = 1'b0; #1;
        chk({m_valid, s_ready}, 2'b11, "R5 opens at once");
        idle_src();
    endtask

    task automatic t_mid_enable();
        gate_en = 1'b0;
        cyc(); s_valid = 1'b1; s_last = 1'b0; #1;
        cyc(); gate_en = 1'b1; #1;
        chk({m_valid, s_ready}, 2'b11, "R10 mid packet open");
        cyc(); s_last = 1'b1; #1;
        chk({m_valid, s_ready}, 2'b11, "R10 last passes");
        cyc(); s_last = 1'b0; #1;
        chk({m_valid, s_ready}, 2'b00, "R10 closed after last");
        cyc(); ack_wr = 1'b1; ack_mask = 2'b10; idle_src(); #1;
        cyc(); #1;
    endtask

    task automatic t_stream();
        // R11: four 3-beat packets, one eot ack per packet
        int got = 0;
        gate_en = 1'b1;
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 3; b++) begin
                cyc(); s_valid = 1'b1; s_data = 32'h100 * p + b; s_last = (b == 2);
                if (b == 0) sot_evt = 1'b1;
                #1;
                if (m_valid && m_ready) got++;
                chk(m_data, 32'h100 * p + b, "R11 order");
                chk(m_valid, 1, "R11 beat delivered");
            end
            cyc(); s_valid = 1'b1; s_data = 32'hDEAD; s_last = 1'b0; eot_evt = 1'b1; #1;
            if (m_valid && m_ready) got++;
            chk(m_valid, 0, "R11 held between packets");
            cyc(); s_valid = 1'b0; ack_wr = 1'b1; ack_mask = 2'b11; #1;
        end
        cyc(); idle_src(); #1;
        chk(got, 12, "R11 beat count");
        chk(irq_pending, 2'b00, "R11 all acked");
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_pass();
        t_no_gate();
        t_close_reopen();
        t_set_wins();
        t_disable_open();
        t_mid_enable();
        t_stream();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule